// File: doc/BRIEF.md
# Overlapped Memory Access Coordinator

This block sits between three memory requesters and a single shared memory bus. The requesters are link data, CPU data and code fetch. Each requester raises a request and gives two attributes with it: whether the address falls in external memory, and whether the access is a write. The block returns a grant for the cycle in which that requester owns the bus. The address decode that sorts requests into internal and external is done upstream and reaches this block as a plain flag.

External memory is slow and only one external access can be in progress at a time. While it runs, the coordinator fills the free bus cycles with accesses to on-chip memory from the other requesters. A requester that also wants external memory during that time is parked as pending, and the parking uses up one cycle. The external access starts with a start pulse and ends with a completion pulse. Its length in cycles is taken from an input sampled at the start pulse, with two cycles as the floor. A write holds the bus only in its first cycle. A read holds the bus in its first cycle and again in its last cycle, when the data comes back. When an external access finishes, the most urgent waiting requester gets the bus in the next cycle.

Top module: `mcoord_top`

## Requirements
- R1: When no external access is in progress, the grant goes to the lowest-numbered active request: index 0 (link data), then index 1 (CPU data), then index 2 (code fetch). At most one grant bit is high in any cycle.
- R2: When a granted request targets external memory and no external access is in progress, `ext_start` is high in the same cycle. `ext_wr` in that cycle equals the requester's write flag.
- R3: `ext_start` is never high while `ext_busy` is high, so only one external access is in progress at a time.
- R4: While an external access is in progress, an internal-target request from a requester that is neither the owner nor pending is granted in that cycle, by the priority of R1, except in a read-return cycle.
- R5: While an external access is in progress, the highest-priority eligible request that targets external memory gets no grant. It becomes pending from the next cycle on, and that cycle goes to no one. The next eligible requester is considered in the following cycle.
- R6: A pending requester is never granted while an external access is in progress. Once every non-owner requester is pending, no grant occurs until the access ends.
- R7: An external write of length L uses the bus only in its start cycle. Cycles 2 to L, including the last, are open to other requesters.
- R8: In the last cycle of an external read, `rd_return` is high, no grant is given, and no new pending mark is made.
- R9: `ext_busy` falls right after the cycle in which `ext_done` is high. In the next cycle the highest-priority request, whether pending or not, is granted with no idle cycle in between.
- R10: An external access lasts `ext_len` cycles, sampled at the start pulse. Any value below 2 counts as 2. `ext_done` is high in the last of these cycles.
- R11: After reset, `grant`, `pending`, `ext_start`, `ext_busy`, `ext_done` and `rd_return` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NREQ | Request per requester, bit 0 is link data, bit 1 CPU data, bit 2 code fetch |
| tgt_ext | input | NREQ | Per requester: 1 means the target is external memory |
| wr | input | NREQ | Per requester: 1 means write |
| ext_len | input | LEN_W | Length of the next external access in cycles (minimum 2) |
| grant | output | NREQ | One-hot grant of the bus for this cycle |
| pending | output | NREQ | Requesters parked while waiting for external memory |
| ext_start | output | 1 | First cycle of an external access |
| ext_wr | output | 1 | The starting external access is a write |
| ext_busy | output | 1 | An external access is past its first cycle |
| ext_done | output | 1 | Last cycle of the external access |
| rd_return | output | 1 | Last cycle of an external read; the bus carries the read data |

## Verification
The grant, the start pulse, the write flag, the done pulse and the return flag are same-cycle decisions. The bench drives them on the falling edge and samples them one time unit later, before the next rising edge. Pending marks and the busy state are registered, so a mark made in cycle N first shows up as `pending` in cycle N+1. The expected values in the table follow that offset. An access of length L shows `ext_done` L-1 cycles after its start cycle, and the next start is expected one cycle after that.

// File: rtl/mcoord_pkg.sv
package mcoord_pkg;
  // requester indices, lower index wins
  typedef enum logic [1:0] {
    RQ_LINK = 2'd0,
    RQ_CPU  = 2'd1,
    RQ_CODE = 2'd2
  } rq_idx_e;

  // shortest external access the responder supports
  localparam int MIN_EXT_LEN = 2;
endpackage

// File: rtl/mcoord_prio_pick.sv
module mcoord_prio_pick #(
  parameter int NREQ = 3
) (
  input  logic [NREQ-1:0] cand,
  output logic [NREQ-1:0] sel
);
  logic [NREQ:0] taken;

  assign taken[0] = 1'b0;

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_pick
      assign sel[i]     = cand[i] & ~taken[i];
      assign taken[i+1] = taken[i] | cand[i];
    end
  endgenerate
endmodule

// File: rtl/mcoord_ext_seq.sv
module mcoord_ext_seq
  import mcoord_pkg::*;
#(
  parameter int NREQ  = 3,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [NREQ-1:0]  start_owner,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             last,
  output logic             rd_ret,
  output logic [NREQ-1:0]  owner
);
  localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_EXT_LEN);
  localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);

  logic [LEN_W-1:0] remain;
  logic             wr_q;
  logic [LEN_W-1:0] eff_len;

  assign eff_len = (len < FLOOR) ? FLOOR : len;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      wr_q   <= 1'b0;
      owner  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= eff_len - ONE;
      wr_q   <= start_wr;
      owner  <= start_owner;
    end else if (busy) begin
      remain <= remain - ONE;
      if (remain == ONE) begin
        busy  <= 1'b0;
        owner <= '0;
      end
    end
  end

  assign last   = busy && (remain == ONE);
  assign rd_ret = last && !wr_q;
endmodule

// File: rtl/mcoord_pend_track.sv
module mcoord_pend_track #(
  parameter int NREQ = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] mark,
  input  logic [NREQ-1:0] grant,
  output logic [NREQ-1:0] pend
);
  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_pend
      always_ff @(posedge clk) begin
        if (rst) pend[i] <= 1'b0;
        else     pend[i] <= (pend[i] | mark[i]) & ~grant[i] & req[i];
      end
    end
  endgenerate
endmodule

// File: rtl/mcoord_top.sv
module mcoord_top #(
  parameter int NREQ  = 3,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREQ-1:0]  req,
  input  logic [NREQ-1:0]  tgt_ext,
  input  logic [NREQ-1:0]  wr,
  input  logic [LEN_W-1:0] ext_len,
  output logic [NREQ-1:0]  grant,
  output logic [NREQ-1:0]  pending,
  output logic             ext_start,
  output logic             ext_wr,
  output logic             ext_busy,
  output logic             ext_done,
  output logic             rd_return
);
  logic            busy, last, ret;
  logic [NREQ-1:0] owner, pend, cand, sel, mark;
  logic            sel_ext, sel_wr;

  // during an access the owner and parked requesters sit out;
  // the read-return cycle belongs to the external data
  assign cand = !busy ? req : (ret ? '0 : (req & ~pend & ~owner));

  mcoord_prio_pick #(.NREQ(NREQ)) u_pick (
    .cand (cand),
    .sel  (sel)
  );

  assign sel_ext = |(sel & tgt_ext);
  assign sel_wr  = |(sel & wr);

  assign grant     = busy ? (sel & ~tgt_ext) : sel;
  assign mark      = busy ? (sel & tgt_ext) : '0;
  assign ext_start = !busy && sel_ext;
  assign ext_wr    = ext_start && sel_wr;

  mcoord_ext_seq #(.NREQ(NREQ), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (ext_start),
    .start_wr    (sel_wr),
    .start_owner (sel),
    .len         (ext_len),
    .busy        (busy),
    .last        (last),
    .rd_ret      (ret),
    .owner       (owner)
  );

  mcoord_pend_track #(.NREQ(NREQ)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .mark  (mark),
    .grant (grant),
    .pend  (pend)
  );

  assign pending   = pend;
  assign ext_busy  = busy;
  assign ext_done  = last;
  assign rd_return = ret;
endmodule

// File: rtl/mcoord_chk.sv
module mcoord_chk #(
  parameter int NREQ = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req,
  input logic [NREQ-1:0] tgt_ext,
  input logic [NREQ-1:0] grant,
  input logic [NREQ-1:0] pending,
  input logic            ext_start,
  input logic            ext_busy,
  input logic            ext_done,
  input logic            rd_return
);
  a_r1_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r1_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);

  a_r2_start_from_ext_req: assert property (@(posedge clk) disable iff (rst)
    ext_start |-> ((grant & req & tgt_ext) != '0));

  a_r3_single_ext: assert property (@(posedge clk) disable iff (rst)
    ext_busy |-> !ext_start);

  a_r5_mark_only_busy: assert property (@(posedge clk) disable iff (rst)
    ((pending & ~$past(pending)) != '0) |-> $past(ext_busy));

  a_r6_pending_blocked: assert property (@(posedge clk) disable iff (rst)
    ext_busy |-> ((grant & pending) == '0));

  a_r8_return_no_grant: assert property (@(posedge clk) disable iff (rst)
    rd_return |-> (grant == '0 && ext_done));

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    ext_done |=> !ext_busy);

  a_r10_start_then_busy: assert property (@(posedge clk) disable iff (rst)
    ext_start |=> ext_busy);
endmodule

bind mcoord_top mcoord_chk #(.NREQ(NREQ)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .tgt_ext   (tgt_ext),
  .grant     (grant),
  .pending   (pending),
  .ext_start (ext_start),
  .ext_busy  (ext_busy),
  .ext_done  (ext_done),
  .rd_return (rd_return)
);

// File: tb/mcoord_top_tb.sv
`timescale 1ns/1ps
module mcoord_top_tb;
  localparam int NREQ  = 3;
  localparam int LEN_W = 4;
  localparam int NV    = 15;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NREQ-1:0]  req = '0, tgt_ext = '0, wr = '0;
  logic [LEN_W-1:0] ext_len = '0;
  logic [NREQ-1:0]  grant, pending;
  logic             ext_start, ext_wr, ext_busy, ext_done, rd_return;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mcoord_top #(.NREQ(NREQ), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .req(req), .tgt_ext(tgt_ext), .wr(wr),
    .ext_len(ext_len), .grant(grant), .pending(pending),
    .ext_start(ext_start), .ext_wr(ext_wr), .ext_busy(ext_busy),
    .ext_done(ext_done), .rd_return(rd_return)
  );

  // {req, ext, we, len, exp_grant, exp_start, exp_wr, exp_ret, exp_pending}
  localparam logic [21:0] VEC [NV] = '{
    {3'b001, 3'b001, 3'b000, 4'd4, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000}, // R1 R2 read start
    {3'b110, 3'b010, 3'b000, 4'd4, 3'b000, 1'b0, 1'b0, 1'b0, 3'b000}, // R5 cpu marked
    {3'b110, 3'b010, 3'b000, 4'd4, 3'b100, 1'b0, 1'b0, 1'b0, 3'b010}, // R4 code internal overlap
    {3'b010, 3'b010, 3'b000, 4'd4, 3'b000, 1'b0, 1'b0, 1'b1, 3'b010}, // R8 read return
    {3'b010, 3'b010, 3'b010, 4'd3, 3'b010, 1'b1, 1'b1, 1'b0, 3'b010}, // R9 pending starts at once
    {3'b101, 3'b101, 3'b000, 4'd3, 3'b000, 1'b0, 1'b0, 1'b0, 3'b000}, // R5 link marked
    {3'b101, 3'b101, 3'b000, 4'd3, 3'b000, 1'b0, 1'b0, 1'b0, 3'b001}, // R7 write last cycle open
    {3'b101, 3'b101, 3'b000, 4'd2, 3'b001, 1'b1, 1'b0, 1'b0, 3'b101}, // R9 R1 link first
    {3'b100, 3'b100, 3'b000, 4'd2, 3'b000, 1'b0, 1'b0, 1'b1, 3'b100}, // R8 short read return
    {3'b100, 3'b100, 3'b100, 4'd2, 3'b100, 1'b1, 1'b1, 1'b0, 3'b100}, // R2 code write
    {3'b011, 3'b000, 3'b000, 4'd2, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000}, // R7 grant in write last cycle
    {3'b010, 3'b000, 3'b000, 4'd2, 3'b010, 1'b0, 1'b0, 1'b0, 3'b000}, // R1 idle internal
    {3'b001, 3'b001, 3'b000, 4'd0, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000}, // R10 len 0 start
    {3'b000, 3'b000, 3'b000, 4'd0, 3'b000, 1'b0, 1'b0, 1'b1, 3'b000}, // R10 clamped to 2
    {3'b110, 3'b000, 3'b000, 4'd0, 3'b010, 1'b0, 1'b0, 1'b0, 3'b000}  // R1 cpu over code
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] r, input logic [2:0] e, input logic [2:0] w,
                      input logic [3:0] l, input logic [2:0] g, input logic s,
                      input logic ew, input logic rt, input logic [2:0] p, input string tag);
    @(negedge clk);
    req = r; tgt_ext = e; wr = w; ext_len = l;
    #1;
    chk({tag, " grant"}, 32'(grant), 32'(g));
    chk({tag, " ext_start"}, 32'(ext_start), 32'(s));
    chk({tag, " ext_wr"}, 32'(ext_wr), 32'(ew));
    chk({tag, " rd_return"}, 32'(rd_return), 32'(rt));
    chk({tag, " pending"}, 32'(pending), 32'(p));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state while reset is held
    chk("R11 grant", 32'(grant), 0);
    chk("R11 pending", 32'(pending), 0);
    chk("R11 busy", 32'(ext_busy), 0);
    chk("R11 done", 32'(ext_done), 0);
    chk("R11 start", 32'(ext_start), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      step(v[21:19], v[18:16], v[15:13], v[12:9], v[8:6], v[5], v[4], v[3], v[2:0],
           $sformatf("table[%0d]", i));
    end

    // R6: both others parked, no overlap until the read of length 6 ends
    step(3'b001, 3'b001, 3'b000, 4'd6, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000, "R6 start");
    step(3'b110, 3'b110, 3'b000, 4'd6, 3'b000, 1'b0, 1'b0, 1'b0, 3'b000, "R5 mark cpu");
    step(3'b110, 3'b110, 3'b000, 4'd6, 3'b000, 1'b0, 1'b0, 1'b0, 3'b010, "R5 mark code");
    step(3'b110, 3'b110, 3'b000, 4'd6, 3'b000, 1'b0, 1'b0, 1'b0, 3'b110, "R6 both parked");
    chk("R10 not done yet", 32'(ext_done), 0);
    step(3'b110, 3'b110, 3'b000, 4'd6, 3'b000, 1'b0, 1'b0, 1'b0, 3'b110, "R6 still parked");
    step(3'b110, 3'b110, 3'b000, 4'd6, 3'b000, 1'b0, 1'b0, 1'b1, 3'b110, "R8 R10 sixth cycle");
    chk("R10 done", 32'(ext_done), 1);
    step(3'b110, 3'b110, 3'b010, 4'd2, 3'b010, 1'b1, 1'b1, 1'b0, 3'b110, "R9 cpu next cycle");
    chk("R3 busy after start", 32'(ext_busy), 0);
    step(3'b100, 3'b100, 3'b000, 4'd2, 3'b000, 1'b0, 1'b0, 1'b0, 3'b100, "R3 no second start");
    chk("R9 busy during write", 32'(ext_busy), 1);
    step(3'b100, 3'b100, 3'b000, 4'd2, 3'b100, 1'b1, 1'b0, 1'b0, 3'b100, "R9 code after write");
    step(3'b000, 3'b000, 3'b000, 4'd2, 3'b000, 1'b0, 1'b0, 1'b1, 3'b000, "R8 code return");

    // R11 reset again mid-access clears everything
    step(3'b001, 3'b001, 3'b000, 4'd5, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000, "R2 pre-reset start");
    @(negedge clk);
    rst = 1'b1; req = '0;
    @(negedge clk);
    #1;
    chk("R11 busy after reset", 32'(ext_busy), 0);
    chk("R11 pending after reset", 32'(pending), 0);
    chk("R11 grant after reset", 32'(grant), 0);
    finish_run();
  end
endmodule